// File: doc/BRIEF.md
# Authenticated Masked Register Update Engine

This engine walks through a list of update entries and applies each one as a read-modify-write to a small internal register file. Every entry arrives as four consecutive 64-bit words on a valid-qualified stream: a target address word, a mask word, a new-value word and a check word. The engine reads the target, keeps only the bits the mask allows and ORs in the new bits. It commits the result only if no authentication check has failed so far in the sequence.

Authentication comes from an external authenticator state input. Each check word carries an expected value. The engine subtracts the authenticator state from it and ORs the difference into a sticky error accumulator. Once that accumulator is nonzero, every later write is blocked and reads are steered to a harmless sentinel register. When the sequence ends, the engine reports pass or fail. On failure it overwrites the four patch-match registers with the no-match code, so a partly applied update cannot activate anything.

A sequence starts with a one-cycle start pulse that carries the entry count. Any register can be read back combinationally through an observation port.

Top module: `reg_patch_engine`

## Requirements
- R1: The target register index is bits [15:0] of the address word, truncated to its low 9 bits. For example, address word 0xFE23 selects register 0x023.
- R2: The committed value is (current register value AND mask word[31:0]) OR new-value word[31:0].
- R3: The read for an entry is taken from sentinel register 0x16F instead of the target in two cases: when auth_i is nonzero in the cycle the mask word is accepted, or when the error accumulator is already nonzero.
- R4: On each check word the accumulator becomes acc OR (check word[31:0] − auth_i). A match leaves it unchanged. The accumulator is cleared only when a new sequence starts, so a failure stays until then.
- R5: An entry's write to its target is committed only if the accumulator is zero after that entry's own check. Otherwise the target keeps its value.
- R6: Words are taken in the order address, mask, new value, check, one word per cycle in which word_valid_i is high. count_i is sampled at start, and the sequence ends after that many entries. A count of zero ends the sequence at once with a pass.
- R7: If the sequence ends with a nonzero accumulator, 0x1FF is written to registers 0x1B8, 0x1B9, 0x1BA and 0x1BB. 0x1FF is the all-ones 9-bit no-match code. On a pass these registers are left untouched.
- R8: At the end of a sequence, done_o pulses high for exactly one cycle. pass_o then shows 1 for a zero accumulator and 0 otherwise, and holds that value until the next start.
- R9: A start pulse while busy_o is high is ignored. The running sequence keeps its entry count.
- R10: After reset, register i holds (i × 0x00010001) XOR 0xC3C30000. busy_o, done_o and pass_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a sequence when idle |
| count_i | input | 8 | Number of entries in the sequence |
| word_valid_i | input | 1 | Entry word is present on word_i |
| word_i | input | 64 | Entry word |
| auth_i | input | 32 | External authenticator state |
| obs_addr_i | input | 9 | Observation read index |
| obs_data_o | output | 32 | Register value at obs_addr_i |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| pass_o | output | 1 | Result of the last sequence |

## Verification
The read-modify-write path is tried with several kinds of entry. Some use split masks and new values, which separate the AND from the OR. Some use an address word with high bits set, which shows the 9-bit truncation. Some use a nonzero authenticator on the mask word, which shows the redirect, because the committed value is then built from register 0x16F. A sequence with a bad check in the middle shows the difference between blocking only the failing write and blocking all writes after it, and it also exposes the neutralisation of the match registers. A later clean sequence, a zero-count run and a start pulse sent mid-sequence separate a per-sequence accumulator clear and count capture from designs that clear or reload at other times.

// File: rtl/rpe_pkg.sv
package rpe_pkg;
  localparam int DATA_W = 32;
  localparam int WORD_W = 64;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_MASK, ST_NEWV, ST_CHECK, ST_FINISH
  } seq_state_t;

  function automatic logic [DATA_W-1:0] merge_bits(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] mask,
    input logic [DATA_W-1:0] nv);
    return (cur & mask) | nv;
  endfunction

  function automatic logic [DATA_W-1:0] check_diff(
    input logic [DATA_W-1:0] expected,
    input logic [DATA_W-1:0] auth);
    return expected - auth;
  endfunction

  function automatic logic [DATA_W-1:0] reset_pattern(input int unsigned idx);
    logic [DATA_W-1:0] v;
    v = DATA_W'(idx) * 32'h0001_0001;
    return v ^ 32'hC3C3_0000;
  endfunction
endpackage

// File: rtl/rpe_regfile.sv
module rpe_regfile import rpe_pkg::*; #(
  parameter int ENTRIES    = 512,
  parameter int MATCH_BASE = 'h1B8,
  parameter int MATCH_CNT  = 4,
  parameter int NOMATCH    = 'h1FF,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              kill_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [AW-1:0]     obs_addr,
  output logic [DATA_W-1:0] obs_data
);
  logic [DATA_W-1:0] mem [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
    localparam bit IS_MATCH = (i >= MATCH_BASE) && (i < MATCH_BASE + MATCH_CNT);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= reset_pattern(i);
      else if (IS_MATCH && kill_en)
        mem[i] <= DATA_W'(NOMATCH);
      else if (wr_en && (wr_addr == AW'(i)))
        mem[i] <= wr_data;
    end
  end

  assign rd_data  = mem[rd_addr];
  assign obs_data = mem[obs_addr];
endmodule

// File: rtl/rpe_acc.sv
module rpe_acc import rpe_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              chk_accept,
  input  logic [DATA_W-1:0] expected,
  input  logic [DATA_W-1:0] auth,
  output logic [DATA_W-1:0] acc_q,
  output logic              clean_after_chk
);
  logic [DATA_W-1:0] acc_next;

  always_comb begin
    acc_next = acc_q;
    if (chk_accept) acc_next = acc_q | check_diff(expected, auth);
  end

  assign clean_after_chk = (acc_next == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else            acc_q <= acc_next;
  end
endmodule

// File: rtl/rpe_seq.sv
module rpe_seq import rpe_pkg::*; #(
  parameter int CNT_W = 8,
  parameter int AW    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              seq_start_o,
  output logic              mask_accept_o,
  output logic              chk_accept_o,
  output logic              finish_o,
  output logic [AW-1:0]     tgt_addr_o,
  output logic [DATA_W-1:0] merged_o
);
  seq_state_t        state_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] cur_q, mask_q;
  logic [15:0]       addr_field;

  assign addr_field    = word_i[15:0];
  assign busy_o        = (state_q != ST_IDLE);
  assign seq_start_o   = (state_q == ST_IDLE) && start_i;
  assign mask_accept_o = (state_q == ST_MASK) && word_valid_i;
  assign chk_accept_o  = (state_q == ST_CHECK) && word_valid_i;
  assign finish_o      = (state_q == ST_FINISH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      left_q     <= '0;
      cur_q      <= '0;
      mask_q     <= '0;
      tgt_addr_o <= '0;
      merged_o   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          left_q  <= count_i;
          state_q <= (count_i == '0) ? ST_FINISH : ST_ADDR;
        end
        ST_ADDR: if (word_valid_i) begin
          tgt_addr_o <= addr_field[AW-1:0];
          state_q    <= ST_MASK;
        end
        ST_MASK: if (word_valid_i) begin
          cur_q   <= rd_data_i;
          mask_q  <= word_i[DATA_W-1:0];
          state_q <= ST_NEWV;
        end
        ST_NEWV: if (word_valid_i) begin
          merged_o <= merge_bits(cur_q, mask_q, word_i[DATA_W-1:0]);
          state_q  <= ST_CHECK;
        end
        ST_CHECK: if (word_valid_i) begin
          left_q  <= left_q - 1'b1;
          state_q <= (left_q == CNT_W'(1)) ? ST_FINISH : ST_ADDR;
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/reg_patch_engine.sv
module reg_patch_engine import rpe_pkg::*; #(
  parameter int ENTRIES    = 512,
  parameter int CNT_W      = 8,
  parameter int SENTINEL   = 'h16F,
  parameter int MATCH_BASE = 'h1B8,
  parameter int MATCH_CNT  = 4,
  parameter int NOMATCH    = 'h1FF,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              word_valid_i,
  input  logic [63:0]       word_i,
  input  logic [31:0]       auth_i,
  input  logic [AW-1:0]     obs_addr_i,
  output logic [31:0]       obs_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o
);
  logic              seq_start, mask_accept, chk_accept, finish;
  logic [AW-1:0]     tgt_addr, rd_addr;
  logic [DATA_W-1:0] rd_data, merged, acc_q;
  logic              clean_after_chk, rf_wr_en, kill_en, redirect;

  rpe_seq #(.CNT_W(CNT_W), .AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .word_valid_i(word_valid_i), .word_i(word_i), .rd_data_i(rd_data),
    .busy_o(busy_o), .seq_start_o(seq_start), .mask_accept_o(mask_accept),
    .chk_accept_o(chk_accept), .finish_o(finish), .tgt_addr_o(tgt_addr),
    .merged_o(merged)
  );

  rpe_acc acc_i (
    .clk(clk), .rst_n(rst_n), .clear(seq_start), .chk_accept(chk_accept),
    .expected(word_i[DATA_W-1:0]), .auth(auth_i), .acc_q(acc_q),
    .clean_after_chk(clean_after_chk)
  );

  assign redirect = (auth_i != '0) || (acc_q != '0);
  assign rd_addr  = redirect ? AW'(SENTINEL) : tgt_addr;
  assign rf_wr_en = chk_accept && clean_after_chk;
  assign kill_en  = finish && (acc_q != '0);

  rpe_regfile #(.ENTRIES(ENTRIES), .MATCH_BASE(MATCH_BASE),
                .MATCH_CNT(MATCH_CNT), .NOMATCH(NOMATCH)) rf_i (
    .clk(clk), .rst_n(rst_n), .wr_en(rf_wr_en), .wr_addr(tgt_addr),
    .wr_data(merged), .kill_en(kill_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .obs_addr(obs_addr_i), .obs_data(obs_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish)         pass_o <= (acc_q == '0);
      else if (seq_start) pass_o <= 1'b0;
    end
  end
endmodule

// File: rtl/reg_patch_engine_chk.sv
module reg_patch_engine_chk #(
  parameter int AW = 9,
  parameter int SENTINEL = 'h16F
) (
  input logic          clk,
  input logic          rst_n,
  input logic          seq_start,
  input logic          mask_accept,
  input logic          rf_wr_en,
  input logic          kill_en,
  input logic          busy_o,
  input logic          done_o,
  input logic          pass_o,
  input logic [31:0]   auth_i,
  input logic [31:0]   acc_q,
  input logic [AW-1:0] rd_addr
);
  a_r5_no_commit_after_error: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (acc_q == '0));

  a_r4_acc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_q != '0) && !seq_start) |=> (acc_q != '0));

  a_r3_sentinel_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_accept && ((auth_i != '0) || (acc_q != '0))) |-> (rd_addr == AW'(SENTINEL)));

  a_r7_kill_on_fail_only: assert property (@(posedge clk) disable iff (!rst_n)
    kill_en |-> (acc_q != '0));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && pass_o) |-> (acc_q == '0));

  a_r6_words_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mask_accept |-> busy_o);
endmodule

bind reg_patch_engine reg_patch_engine_chk #(.AW(AW), .SENTINEL(SENTINEL)) chk_i (
  .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .mask_accept(mask_accept),
  .rf_wr_en(rf_wr_en), .kill_en(kill_en), .busy_o(busy_o), .done_o(done_o),
  .pass_o(pass_o), .auth_i(auth_i), .acc_q(acc_q), .rd_addr(rd_addr)
);

// File: tb/reg_patch_engine_tb.sv
module reg_patch_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  count_i = '0;
  logic        word_valid_i = 1'b0;
  logic [63:0] word_i = '0;
  logic [31:0] auth_i = '0;
  logic [8:0]  obs_addr_i = '0;
  logic [31:0] obs_data_o;
  logic        busy_o, done_o, pass_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [512];

  always #2.5 clk = ~clk;

  reg_patch_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .word_valid_i(word_valid_i), .word_i(word_i), .auth_i(auth_i),
    .obs_addr_i(obs_addr_i), .obs_data_o(obs_data_o), .busy_o(busy_o),
    .done_o(done_o), .pass_o(pass_o)
  );

  function automatic logic [31:0] init_val(int i);
    logic [31:0] k = 32'(i);
    return ((k << 16) + k) ^ 32'hC3C3_0000;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic check_reg(string req, int idx);
    @(negedge clk);
    obs_addr_i = 9'(idx);
    #1;
    check(req, obs_data_o, model[idx]);
  endtask

  task automatic begin_seq(int n);
    @(negedge clk);
    start_i = 1'b1;
    count_i = 8'(n);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic put_word(logic [63:0] w, logic [31:0] a);
    word_valid_i = 1'b1;
    word_i = w;
    auth_i = a;
    @(negedge clk);
    word_valid_i = 1'b0;
    auth_i = '0;
  endtask

  // One entry; good=1 makes auth match the check word. sent: mask step auth.
  task automatic entry(logic [63:0] aw, logic [31:0] m, logic [31:0] nv,
                       logic [31:0] ck, bit good, logic [31:0] sent_auth);
    put_word(aw, 32'h0);
    put_word({32'h0, m}, sent_auth);
    put_word({32'h0, nv}, 32'h0);
    put_word({32'hFFFF_FFFF, ck}, good ? ck : ck ^ 32'h0000_0100);
  endtask

  task automatic wait_done(string req, logic exp_pass);
    bit seen = 0;
    for (int k = 0; k < 10 && !seen; k++) begin
      if (done_o) seen = 1;
      else @(negedge clk);
    end
    check({req, " done"}, 32'(seen), 32'd1);
    check({req, " pass"}, 32'(pass_o), 32'(exp_pass));
    @(negedge clk);
    check({req, " done one cycle"}, 32'(done_o), 32'd0);
  endtask

  task automatic t_reset;
    check("R10 busy", 32'(busy_o), 0);
    check("R10 done", 32'(done_o), 0);
    check("R10 pass", 32'(pass_o), 0);
    check_reg("R10 reg5", 5);
    check_reg("R10 reg1FF", 'h1FF);
  endtask

  task automatic t_single_pass;
    begin_seq(1);
    entry(64'h0000_0000_0000_0010, 32'hFFFF_0000, 32'h0000_1234, 32'h0000_ABCD, 1, 0);
    model['h10] = (model['h10] & 32'hFFFF_0000) | 32'h0000_1234;
    wait_done("R2 single", 1);
    check_reg("R2 merged value", 'h10);
    check_reg("R7 match untouched on pass", 'h1B8);
  endtask

  task automatic t_multi_trunc;
    begin_seq(2);
    entry(64'hABCD_0001_0000_FE23, 32'h00FF_00FF, 32'h1100_2200, 32'h1357_9BDF, 1, 0);
    entry(64'h0000_0000_0000_0031, 32'h0000_0000, 32'hDEAD_BEEF, 32'h0000_0000, 1, 0);
    model['h23] = (model['h23] & 32'h00FF_00FF) | 32'h1100_2200;
    model['h31] = 32'hDEAD_BEEF;
    wait_done("R1 multi", 1);
    check_reg("R1 truncated index", 'h23);
    check_reg("R6 second entry", 'h31);
  endtask

  task automatic t_sentinel;
    begin_seq(1);
    entry(64'h40, 32'hFFFF_FFFF, 32'h0, 32'h0000_0777, 1, 32'h0000_0005);
    model['h40] = model['h16F];
    wait_done("R3 sentinel", 1);
    check_reg("R3 value from 0x16F", 'h40);
  endtask

  task automatic t_fail;
    begin_seq(3);
    entry(64'h50, 32'h0, 32'h5555_0000, 32'h0000_0042, 1, 0);
    entry(64'h51, 32'h0, 32'h6666_0000, 32'h0000_0099, 0, 0);
    entry(64'h52, 32'h0, 32'h7777_0000, 32'h0000_0011, 1, 0);
    model['h50] = 32'h5555_0000;
    wait_done("R4 fail", 0);
    check_reg("R4 good entry before fail", 'h50);
    check_reg("R5 failing entry blocked", 'h51);
    check_reg("R5 later entry blocked", 'h52);
    for (int a = 'h1B8; a <= 'h1BB; a++) begin
      model[a] = 32'h0000_01FF;
      check_reg("R7 neutralised", a);
    end
  endtask

  task automatic t_recover;
    begin_seq(1);
    check("R8 pass cleared on start", 32'(pass_o), 0);
    entry(64'h60, 32'h0, 32'h0BAD_F00D, 32'h0000_1000, 1, 0);
    model['h60] = 32'h0BAD_F00D;
    wait_done("R4 acc cleared", 1);
    check_reg("R4 write after clear", 'h60);
  endtask

  task automatic t_zero;
    begin_seq(0);
    wait_done("R6 zero count", 1);
    check("R6 idle after zero", 32'(busy_o), 0);
  endtask

  task automatic t_busy_start;
    begin_seq(1);
    put_word(64'h70, 32'h0);
    start_i = 1'b1;
    count_i = 8'd3;
    put_word({32'h0, 32'h0}, 32'h0);
    start_i = 1'b0;
    put_word({32'h0, 32'h0000_7070}, 32'h0);
    put_word({32'h0, 32'h0000_0003}, 32'h0000_0003);
    model['h70] = 32'h0000_7070;
    wait_done("R9 start ignored", 1);
    check_reg("R9 entry applied", 'h70);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) model[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_pass();
    t_multi_trunc();
    t_sentinel();
    t_fail();
    t_recover();
    t_zero();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule